// File: doc/BRIEF.md
# USB Device Configuration Command Unit

This unit sits between a local microcontroller and the endpoint and address logic of a full-speed USB device core. The microcontroller selects a register with a one-byte command code, then moves exactly one data byte with a write strobe or a read strobe. The unit holds one configuration byte for each of sixteen endpoints and one device address byte. Each endpoint byte is decoded into enable, direction, double-buffer, isochronous and size outputs for the FIFO manager. The direction is also exported as a separate DMA-direction output.

The address the microcontroller writes is kept apart from the active address that the bus logic matches against. A new address waits until the host has acknowledged the empty status stage, and only then does it take effect. A USB bus reset clears the active address and enables the device, but it leaves the readable register alone. When a write changes an endpoint's allocation (its enable bit or its size field), the unit pulses a flush-all strobe, because the contents of every FIFO are then void.

Top module: `usb_cfg_cmd_unit`

## Requirements
- R1: After an asynchronous reset, every endpoint output, `flush_all_o`, `rd_vld_o`, `dev_addr_o` and `dev_en_o` are zero, and reading any register returns 0x00.
- R2: The command code 0x20+n, followed by a data write strobe, stores the byte in endpoint n's configuration, where n = 0 is control OUT, n = 1 is control IN, and n = 2..15 are endpoints 1..14. In that byte, bit 7 is the enable, bit 6 the direction (1 = IN), bit 5 the double buffer, bit 4 isochronous, and bits 3:0 the size. The fields appear on the per-endpoint outputs after the strobe's clock edge, and other endpoints keep their values.
- R3: The command code 0x30+n, followed by a data read strobe, returns endpoint n's byte on `rd_data_o` with `rd_vld_o` high for one cycle, starting one cycle after the strobe.
- R4: `dma_dir_o[n]` follows bit 6 of endpoint n's byte, where 1 means a DMA write and 0 means a DMA read.
- R5: An endpoint write that changes the enable bit or the size field raises `flush_all_o` for exactly one cycle, in the cycle after the strobe edge.
- R6: A write that leaves the enable bit and size unchanged does not raise `flush_all_o`. This holds even when it alters the direction, double-buffer or isochronous bits.
- R7: Code 0xB6 writes the address register, where bit 7 is the device enable and bits 6:0 are the address. Code 0xB7 reads the register back. A write does not change `dev_addr_o` or `dev_en_o`.
- R8: A `status_ack_i` pulse after an address write copies the register into `dev_addr_o`/`dev_en_o`. A pulse with no write pending changes nothing.
- R9: `bus_reset_i` sets `dev_addr_o` to 0 and `dev_en_o` to 1 on the next edge, discards any pending update, and leaves the 0xB7 readback unchanged.
- R10: When `bus_reset_i` and `status_ack_i` arrive in the same cycle, the bus reset takes effect and the pending address is dropped, so a later acknowledge has no effect.
- R11: A code outside 0x20-0x3F, 0xB6 and 0xB7 changes no register and reads back as 0x00. A data strobe whose direction does not match the armed command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command code strobe |
| cmd_code_i | input | 8 | Command code |
| dat_wr_i | input | 1 | Data write strobe |
| dat_wr_data_i | input | 8 | Data byte to write |
| dat_rd_i | input | 1 | Data read strobe |
| rd_data_o | output | 8 | Read data |
| rd_vld_o | output | 1 | Read data valid, one cycle |
| bus_reset_i | input | 1 | USB bus reset seen |
| status_ack_i | input | 1 | Host acknowledged the empty status packet |
| ep_en_o | output | NUM_EP | Endpoint FIFO enable |
| ep_dir_o | output | NUM_EP | Endpoint direction, 1 = IN |
| ep_dbuf_o | output | NUM_EP | Double buffering |
| ep_iso_o | output | NUM_EP | Isochronous |
| ep_size_o | output | 4*NUM_EP | Size codes, endpoint n at bits 4n+3:4n |
| dma_dir_o | output | NUM_EP | DMA direction, 1 = write |
| flush_all_o | output | 1 | Invalidate all FIFOs, one-cycle pulse |
| dev_addr_o | output | 7 | Active device address |
| dev_en_o | output | 1 | Active device enable |

## Verification
Several write patterns are applied to endpoint configuration. A first enable write and a size-only change must flush. A write that toggles only the direction, double-buffer or isochronous bits, and a rewrite of the same value, must not flush, so a design that flushes on any change or on any write is caught. Writing the two end indices, control OUT and endpoint 14, then reading both back, separates correct index decode from aliasing between endpoints. The address tests order a write, an acknowledge, a bus reset, and a reset that coincides with an acknowledge. This separates deferred activation from immediate activation and shows whether the readable register is kept apart from the active copy.

// File: rtl/usbcfg_pkg.sv
package usbcfg_pkg;
  localparam int unsigned CODE_W     = 8;
  localparam int unsigned SIZE_W     = 4;
  localparam int unsigned DEV_ADDR_W = 7;
  localparam int unsigned IDX_W      = 4;

  localparam logic [3:0]        EP_WR_HI    = 4'h2;
  localparam logic [3:0]        EP_RD_HI    = 4'h3;
  localparam logic [CODE_W-1:0] ADR_WR_CODE = 8'hB6;
  localparam logic [CODE_W-1:0] ADR_RD_CODE = 8'hB7;

  typedef enum logic [2:0] {
    OP_NONE, OP_EP_WR, OP_EP_RD, OP_ADR_WR, OP_ADR_RD
  } op_e;

  // bit order equals the byte seen by firmware: en, dir, dbuf, iso, size
  typedef struct packed {
    logic              en;
    logic              dir;
    logic              dbuf;
    logic              iso;
    logic [SIZE_W-1:0] size;
  } ep_cfg_t;
endpackage

// File: rtl/usbcfg_cmd_decode.sv
module usbcfg_cmd_decode
  import usbcfg_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output op_e               op_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = code_i[IDX_W-1:0];
    op_o  = OP_NONE;
    if (code_i[7:4] == EP_WR_HI)      op_o = OP_EP_WR;
    else if (code_i[7:4] == EP_RD_HI) op_o = OP_EP_RD;
    else if (code_i == ADR_WR_CODE)   op_o = OP_ADR_WR;
    else if (code_i == ADR_RD_CODE)   op_o = OP_ADR_RD;
  end
endmodule

// File: rtl/usbcfg_ep_bank.sv
module usbcfg_ep_bank
  import usbcfg_pkg::*;
#(
  parameter int unsigned NUM_EP = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  ep_cfg_t                 wr_data_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output ep_cfg_t                 rd_data_o,
  output ep_cfg_t [NUM_EP-1:0]    cfg_o,
  output logic                    flush_o
);
  localparam logic [IDX_W:0] EP_LIM = (IDX_W+1)'(NUM_EP);

  ep_cfg_t [NUM_EP-1:0] cfg_q;
  logic    wr_hit, rd_hit, alloc_chg, flush_q;
  ep_cfg_t old_cfg;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_cfg_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    q <= '0;
      else if (wr_hit && wr_idx_i == IDX_W'(i))       q <= wr_data_i;
    end
    assign cfg_q[i] = q;
  end

  assign wr_hit  = wr_en_i && ({1'b0, wr_idx_i} < EP_LIM);
  assign rd_hit  = {1'b0, rd_idx_i} < EP_LIM;
  assign old_cfg = wr_hit ? cfg_q[wr_idx_i] : '0;

  // only allocation fields (enable, size) void the FIFO memory
  assign alloc_chg = wr_hit &&
                     ((old_cfg.en != wr_data_i.en) || (old_cfg.size != wr_data_i.size));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= alloc_chg;
  end

  assign rd_data_o = rd_hit ? cfg_q[rd_idx_i] : '0;
  assign cfg_o     = cfg_q;
  assign flush_o   = flush_q;
endmodule

// File: rtl/usbcfg_addr_unit.sv
module usbcfg_addr_unit
  import usbcfg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CODE_W-1:0]     wr_data_i,
  input  logic                  bus_reset_i,
  input  logic                  status_ack_i,
  output logic [CODE_W-1:0]     reg_o,
  output logic [DEV_ADDR_W-1:0] act_addr_o,
  output logic                  act_en_o
);
  logic [CODE_W-1:0]     reg_q;
  logic [DEV_ADDR_W-1:0] act_addr_q;
  logic                  act_en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q      <= '0;
      act_addr_q <= '0;
      act_en_q   <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      if (wr_en_i) reg_q <= wr_data_i;
      // bus reset outranks a coincident acknowledge
      if (bus_reset_i) begin
        act_addr_q <= '0;
        act_en_q   <= 1'b1;
        pend_q     <= 1'b0;
      end else if (status_ack_i && pend_q) begin
        act_addr_q <= reg_q[DEV_ADDR_W-1:0];
        act_en_q   <= reg_q[CODE_W-1];
        pend_q     <= 1'b0;
      end
      if (wr_en_i) pend_q <= 1'b1;
    end
  end

  assign reg_o      = reg_q;
  assign act_addr_o = act_addr_q;
  assign act_en_o   = act_en_q;
endmodule

// File: rtl/usb_cfg_cmd_unit.sv
module usb_cfg_cmd_unit
  import usbcfg_pkg::*;
#(
  parameter int unsigned NUM_EP = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_vld_i,
  input  logic [7:0]                 cmd_code_i,
  input  logic                       dat_wr_i,
  input  logic [7:0]                 dat_wr_data_i,
  input  logic                       dat_rd_i,
  output logic [7:0]                 rd_data_o,
  output logic                       rd_vld_o,
  input  logic                       bus_reset_i,
  input  logic                       status_ack_i,
  output logic [NUM_EP-1:0]          ep_en_o,
  output logic [NUM_EP-1:0]          ep_dir_o,
  output logic [NUM_EP-1:0]          ep_dbuf_o,
  output logic [NUM_EP-1:0]          ep_iso_o,
  output logic [4*NUM_EP-1:0]        ep_size_o,
  output logic [NUM_EP-1:0]          dma_dir_o,
  output logic                       flush_all_o,
  output logic [6:0]                 dev_addr_o,
  output logic                       dev_en_o
);
  op_e                  dec_op, op_q;
  logic [IDX_W-1:0]     dec_idx, idx_q;
  logic                 armed_q, wr_fire, rd_fire, rd_vld_q;
  logic [CODE_W-1:0]    rd_q, rd_mux, adr_reg;
  ep_cfg_t              ep_rd;
  ep_cfg_t [NUM_EP-1:0] ep_cfg;

  usbcfg_cmd_decode u_dec (
    .code_i (cmd_code_i),
    .op_o   (dec_op),
    .idx_o  (dec_idx)
  );

  // a new command re-arms; any data strobe consumes the armed command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_NONE;
      idx_q   <= '0;
      armed_q <= 1'b0;
    end else if (cmd_vld_i) begin
      op_q    <= dec_op;
      idx_q   <= dec_idx;
      armed_q <= 1'b1;
    end else if (dat_wr_i || dat_rd_i) begin
      armed_q <= 1'b0;
    end
  end

  assign wr_fire = armed_q && !cmd_vld_i && dat_wr_i;
  assign rd_fire = armed_q && !cmd_vld_i && dat_rd_i && !dat_wr_i;

  usbcfg_ep_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_fire && op_q == OP_EP_WR),
    .wr_idx_i  (idx_q),
    .wr_data_i (ep_cfg_t'(dat_wr_data_i)),
    .rd_idx_i  (idx_q),
    .rd_data_o (ep_rd),
    .cfg_o     (ep_cfg),
    .flush_o   (flush_all_o)
  );

  usbcfg_addr_unit u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_fire && op_q == OP_ADR_WR),
    .wr_data_i    (dat_wr_data_i),
    .bus_reset_i  (bus_reset_i),
    .status_ack_i (status_ack_i),
    .reg_o        (adr_reg),
    .act_addr_o   (dev_addr_o),
    .act_en_o     (dev_en_o)
  );

  always_comb begin
    case (op_q)
      OP_EP_RD:  rd_mux = ep_rd;
      OP_ADR_RD: rd_mux = adr_reg;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= rd_fire;
      if (rd_fire) rd_q <= rd_mux;
    end
  end

  assign rd_data_o = rd_q;
  assign rd_vld_o  = rd_vld_q;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_out
    assign ep_en_o[i]           = ep_cfg[i].en;
    assign ep_dir_o[i]          = ep_cfg[i].dir;
    assign ep_dbuf_o[i]         = ep_cfg[i].dbuf;
    assign ep_iso_o[i]          = ep_cfg[i].iso;
    assign ep_size_o[4*i +: 4]  = ep_cfg[i].size;
    assign dma_dir_o[i]         = ep_cfg[i].dir;
  end
endmodule

// File: rtl/usbcfg_checker.sv
module usbcfg_checker #(
  parameter int unsigned NUM_EP = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                dat_wr_i,
  input logic                dat_rd_i,
  input logic                rd_vld_o,
  input logic                bus_reset_i,
  input logic                status_ack_i,
  input logic [NUM_EP-1:0]   ep_en_o,
  input logic [4*NUM_EP-1:0] ep_size_o,
  input logic                flush_all_o,
  input logic [6:0]          dev_addr_o,
  input logic                dev_en_o
);
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dat_wr_i) |-> ($stable(ep_en_o) && $stable(ep_size_o)));

  p_rd_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(dat_rd_i));

  p_flush_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |=> !flush_all_o);

  p_flush_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |-> (!$stable(ep_en_o) || !$stable(ep_size_o)));

  p_no_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(ep_en_o) && $stable(ep_size_o)) |-> !flush_all_o);

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_reset_i && !status_ack_i) |=> ($stable(dev_addr_o) && $stable(dev_en_o)));

  p_bus_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (dev_addr_o == 7'd0 && dev_en_o));

  p_reset_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i && status_ack_i) |=> (dev_addr_o == 7'd0));
endmodule

bind usb_cfg_cmd_unit usbcfg_checker #(.NUM_EP(NUM_EP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dat_wr_i     (dat_wr_i),
  .dat_rd_i     (dat_rd_i),
  .rd_vld_o     (rd_vld_o),
  .bus_reset_i  (bus_reset_i),
  .status_ack_i (status_ack_i),
  .ep_en_o      (ep_en_o),
  .ep_size_o    (ep_size_o),
  .flush_all_o  (flush_all_o),
  .dev_addr_o   (dev_addr_o),
  .dev_en_o     (dev_en_o)
);

// File: tb/usb_cfg_cmd_unit_bench.sv
module usb_cfg_cmd_unit_bench;
  localparam int NUM_EP = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_vld = 0, dat_wr = 0, dat_rd = 0, bus_rst = 0, ack = 0;
  logic [7:0] cmd_code = 0, wr_data = 0;
  logic [7:0] rd_data;
  logic rd_vld, flush, dev_en;
  logic [6:0] dev_addr;
  logic [NUM_EP-1:0] ep_en, ep_dir, ep_dbuf, ep_iso, dma_dir;
  logic [4*NUM_EP-1:0] ep_size;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #4 clk = ~clk;

  usb_cfg_cmd_unit #(.NUM_EP(NUM_EP)) u_usb_cfg_cmd_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld), .cmd_code_i(cmd_code),
    .dat_wr_i(dat_wr), .dat_wr_data_i(wr_data), .dat_rd_i(dat_rd),
    .rd_data_o(rd_data), .rd_vld_o(rd_vld), .bus_reset_i(bus_rst),
    .status_ack_i(ack), .ep_en_o(ep_en), .ep_dir_o(ep_dir), .ep_dbuf_o(ep_dbuf),
    .ep_iso_o(ep_iso), .ep_size_o(ep_size), .dma_dir_o(dma_dir),
    .flush_all_o(flush), .dev_addr_o(dev_addr), .dev_en_o(dev_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (rst_ni && rd_vld) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", 64'(rd_data), 64'hFFFF);
      else chk(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
    end
  end

  task automatic send_cmd(input logic [7:0] code);
    @(negedge clk); cmd_vld = 1; cmd_code = code;
    @(negedge clk); cmd_vld = 0;
  endtask

  // returns flush_all_o as seen in the cycle after the write edge
  task automatic wr_byte(input logic [7:0] code, input logic [7:0] d, output logic fl);
    send_cmd(code);
    dat_wr = 1; wr_data = d;
    @(negedge clk); dat_wr = 0;
    fl = flush;
  endtask

  task automatic rd_byte(input logic [7:0] code, input logic [7:0] exp, input string tag);
    send_cmd(code);
    exp_q.push_back(exp); tag_q.push_back(tag);
    dat_rd = 1;
    @(negedge clk); dat_rd = 0;
    @(negedge clk);
  endtask

  task automatic pulse(input bit r, input bit a);
    @(negedge clk); bus_rst = r; ack = a;
    @(negedge clk); bus_rst = 0; ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic fl;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ep_en", 64'(ep_en), 0);
    chk("R1 ep_size", ep_size, 0);
    chk("R1 flush/dev", {flush, dev_en, dev_addr, rd_vld}, 0);
    rd_byte(8'h35, 8'h00, "R1 ep5 readback");
    rd_byte(8'hB7, 8'h00, "R1 addr readback");

    // R2/R5 first enable on control OUT
    wr_byte(8'h20, 8'h85, fl);
    chk("R5 flush on enable", 64'(fl), 1);
    @(negedge clk);
    chk("R5 flush one cycle", 64'(flush), 0);
    chk("R2 ep0 en", 64'(ep_en[0]), 1);
    chk("R2 ep0 size", 64'(ep_size[3:0]), 5);
    rd_byte(8'h30, 8'h85, "R3 ep0 readback");

    // R2/R4 endpoint 14 (index 15)
    wr_byte(8'h2F, 8'hC3, fl);
    chk("R5 flush ep15", 64'(fl), 1);
    chk("R4 dma_dir ep15", 64'(dma_dir[15]), 1);
    chk("R2 ep_dir ep15", 64'(ep_dir[15]), 1);
    chk("R4 dma_dir ep0", 64'(dma_dir[0]), 0);
    chk("R2 ep15 size", 64'(ep_size[63:60]), 3);
    rd_byte(8'h3F, 8'hC3, "R3 ep15 readback");
    rd_byte(8'h30, 8'h85, "R2 ep0 kept");

    // R6 non-allocation changes
    wr_byte(8'h2F, 8'hF3, fl);
    chk("R6 no flush dbuf/iso", 64'(fl), 0);
    chk("R2 ep15 dbuf/iso", 64'({ep_dbuf[15], ep_iso[15]}), 2'b11);
    wr_byte(8'h2F, 8'hB3, fl);
    chk("R6 no flush dir", 64'(fl), 0);
    chk("R4 dma_dir cleared", 64'(dma_dir[15]), 0);
    wr_byte(8'h2F, 8'hB3, fl);
    chk("R6 no flush same", 64'(fl), 0);
    wr_byte(8'h2F, 8'hB4, fl);
    chk("R5 flush size", 64'(fl), 1);
    wr_byte(8'h2F, 8'h34, fl);
    chk("R5 flush disable", 64'(fl), 1);
    rd_byte(8'h3F, 8'h34, "R3 ep15 final");

    // R11 unknown code and mismatched strobe
    wr_byte(8'h40, 8'hFF, fl);
    chk("R11 no flush", 64'(fl), 0);
    chk("R11 ep_en kept", 64'(ep_en), 64'h0001);
    rd_byte(8'h50, 8'h00, "R11 unknown read");
    wr_byte(8'h35, 8'hFF, fl);
    rd_byte(8'h35, 8'h00, "R11 mismatched strobe");
    rd_byte(8'hB7, 8'h00, "R11 addr untouched");

    // R7 deferred address
    wr_byte(8'hB6, 8'hAA, fl);
    chk("R7 addr not active", 64'({dev_en, dev_addr}), 0);
    rd_byte(8'hB7, 8'hAA, "R7 addr readback");
    chk("R7 still inactive", 64'({dev_en, dev_addr}), 0);
    // R8 acknowledge activates
    pulse(0, 1);
    chk("R8 addr active", 64'({dev_en, dev_addr}), 64'h0AA);

    // R9 bus reset
    pulse(1, 0);
    chk("R9 bus reset addr", 64'({dev_en, dev_addr}), 64'h080);
    rd_byte(8'hB7, 8'hAA, "R9 register kept");
    // R8 ack with nothing pending
    pulse(0, 1);
    chk("R8 ack no pending", 64'({dev_en, dev_addr}), 64'h080);

    // R10 reset and ack together
    wr_byte(8'hB6, 8'h91, fl);
    pulse(1, 1);
    chk("R10 reset wins", 64'({dev_en, dev_addr}), 64'h080);
    pulse(0, 1);
    chk("R10 pending dropped", 64'({dev_en, dev_addr}), 64'h080);
    rd_byte(8'hB7, 8'h91, "R10 register kept");

    repeat (3) @(negedge clk);
    chk("R3 queue drained", 64'(exp_q.size()), 0);
    done = 1;
    summary();
  end
endmodule